// File: doc/BRIEF.md
# Block Transfer Address Generator

This block generates the word addresses for a multi-register memory transfer. It takes a base address, a 16-bit register selection mask and an ordering mode. After a start strobe it emits one register index and one address on each cycle until every selected register has been served. It then presents the updated base value for an optional writeback. The caller can name the ordering directly as one of four before/after and up/down combinations. It can instead name a stack discipline (full or empty, ascending or descending). In that case the block resolves the discipline one way for pops (loads) and another way for pushes (stores).

The controller is a three-state machine. `ST_IDLE` waits for `start`. On `start` it takes the transition *launch* to `ST_RUN` when the mask has bits set, or the transition *skip* to `ST_FIN` when the mask is empty. `ST_RUN` emits one transfer per cycle and stays there (*advance*) until the transfer of the highest selected register, then takes *drain* to `ST_FIN`. `ST_FIN` holds `done` and the writeback value for one cycle and returns to `ST_IDLE` (*retire*). Memory access, data movement and faults are handled elsewhere.

Top module: `blk_xfer_agen`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `busy`, `xfer_valid`, `done` and `wb_valid` are all 0.
- R2: With `mode_sel`=0 (up, step after), the N selected registers get addresses base, base+4, …, base+4(N-1).
- R3: With `mode_sel`=1 (up, step before), the addresses run from base+4 to base+4N.
- R4: With `mode_sel`=2 (down, step after), the addresses run from base-4N+4 to base.
- R5: With `mode_sel`=3 (down, step before), the addresses run from base-4N to base-4.
- R6: Transfers come on consecutive cycles starting one cycle after the accepted start. They go in ascending register index, each address is 4 above the one before, and bit 15 (the program counter) may be selected. `xfer_last` is high only with the highest selected index.
- R7: One cycle after the last transfer, `done` is high for one cycle. `wb_valid` equals the `wb_en` captured at start, and `wb_addr` is base+4N for modes 0/1 or base-4N for modes 2/3, modulo 2^32.
- R8: An empty mask produces no transfer, and `done` is high exactly one cycle after the start.
- R9: With `alias_en`=1 and `is_load`=1, `stack_kind` (bit1 = ascending, bit0 = empty) resolves full-descending to mode 0, empty-descending to 1, full-ascending to 2 and empty-ascending to 3. `mode_sel` is ignored.
- R10: With `alias_en`=1 and `is_load`=0, empty-ascending resolves to mode 0, full-ascending to 1, empty-descending to 2 and full-descending to 3.
- R11: A `start` that arrives while `busy` is 1 is ignored. The running sequence and its writeback are unchanged, and no extra sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence; sampled only when idle |
| base_addr | input | 32 | Base address |
| reg_list | input | 16 | Register selection mask, bit i selects register i |
| mode_sel | input | 2 | Direct ordering: 0 up/after, 1 up/before, 2 down/after, 3 down/before |
| alias_en | input | 1 | 1: derive the ordering from `stack_kind` and `is_load` |
| is_load | input | 1 | 1: pop (load), 0: push (store) |
| stack_kind | input | 2 | bit1 ascending, bit0 empty |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress (RUN or FIN) |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_last | output | 1 | This is the final transfer |
| done | output | 1 | Sequence finished, one cycle |
| wb_valid | output | 1 | Writeback value is to be applied |
| wb_addr | output | 32 | Updated base value |

## Verification
The first transfer is due one cycle after the edge that accepts `start`. Transfer k is due k cycles after that. `done` and the writeback come one cycle after the last transfer, so for an empty mask they come one cycle after the start. When a start is accepted, the bench's model queues one expected record per cycle. Inputs change just after a falling edge, and the outputs are compared on the next falling edge, one rising edge later. Each record therefore lines up with the register stage it describes, and an empty queue means an idle expectation.

// File: rtl/agen_pkg.sv
package agen_pkg;

    // Ordering: bit1 = downward, bit0 = step before use
    typedef enum logic [1:0] {
        AM_UP_AFTER    = 2'd0,
        AM_UP_BEFORE   = 2'd1,
        AM_DOWN_AFTER  = 2'd2,
        AM_DOWN_BEFORE = 2'd3
    } agen_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } agen_state_e;

endpackage

// File: rtl/agen_mode_map.sv
module agen_mode_map
    import agen_pkg::*;
(
    input  logic       alias_en,
    input  logic       is_load,
    input  logic [1:0] direct_mode,
    input  logic [1:0] stack_kind,
    output agen_mode_e mode
);

    // stack_kind: bit1 ascending, bit0 empty
    always_comb begin
        if (!alias_en) begin
            mode = agen_mode_e'(direct_mode);
        end else if (is_load) begin
            // pops: FD->up/after, ED->up/before, FA->down/after, EA->down/before
            mode = agen_mode_e'(stack_kind);
        end else begin
            // pushes: EA->up/after, FA->up/before, ED->down/after, FD->down/before
            mode = agen_mode_e'(~stack_kind);
        end
    end

endmodule

// File: rtl/agen_low_pick.sv
module agen_low_pick #(
    parameter int LIST_W = 16,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] mask,
    output logic [LIST_W-1:0] first_oh,
    output logic [IDX_W-1:0]  first_idx,
    output logic              single
);

    logic [LIST_W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < LIST_W; i++) begin : g_chain
        assign seen[i+1]   = seen[i] | mask[i];
        assign first_oh[i] = mask[i] & ~seen[i];
    end

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < LIST_W; i++) begin
            if (first_oh[i]) first_idx = IDX_W'(i);
        end
    end

    assign single = seen[LIST_W] && ((mask & ~first_oh) == '0);

endmodule

// File: rtl/agen_span_calc.sv
module agen_span_calc
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    parameter int STEP   = 4,
    localparam int CNT_W = $clog2(LIST_W + 1),
    localparam int SH    = $clog2(STEP)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LIST_W-1:0] mask,
    input  agen_mode_e        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_base
);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < LIST_W; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    assign span = ADDR_W'(cnt) << SH;

    always_comb begin
        unique case (mode)
            AM_UP_AFTER:    first_addr = base;
            AM_UP_BEFORE:   first_addr = base + ADDR_W'(STEP);
            AM_DOWN_AFTER:  first_addr = base - span + ADDR_W'(STEP);
            AM_DOWN_BEFORE: first_addr = base - span;
            default:        first_addr = base;
        endcase
    end

    assign final_base = mode[1] ? (base - span) : (base + span);

endmodule

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    parameter int STEP   = 4,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LIST_W-1:0] reg_list,
    input  logic [1:0]        mode_sel,
    input  logic              alias_en,
    input  logic              is_load,
    input  logic [1:0]        stack_kind,
    input  logic              wb_en,
    output logic              busy,
    output logic              xfer_valid,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_last,
    output logic              done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);

    agen_state_e       state, state_nx;
    logic [LIST_W-1:0] pend, pend_nx;
    logic [ADDR_W-1:0] cur_addr, addr_nx;
    logic [ADDR_W-1:0] wb_q, wb_nx;
    logic              wben_q, wben_nx;

    agen_mode_e        eff_mode;
    logic [ADDR_W-1:0] calc_first, calc_final;
    logic [LIST_W-1:0] pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_single;

    agen_mode_map u_map (
        .alias_en    (alias_en),
        .is_load     (is_load),
        .direct_mode (mode_sel),
        .stack_kind  (stack_kind),
        .mode        (eff_mode)
    );

    agen_span_calc #(
        .ADDR_W (ADDR_W),
        .LIST_W (LIST_W),
        .STEP   (STEP)
    ) u_span (
        .base       (base_addr),
        .mask       (reg_list),
        .mode       (eff_mode),
        .first_addr (calc_first),
        .final_base (calc_final)
    );

    agen_low_pick #(
        .LIST_W (LIST_W)
    ) u_pick (
        .mask      (pend),
        .first_oh  (pick_oh),
        .first_idx (pick_idx),
        .single    (pick_single)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= '0;
            cur_addr <= '0;
            wb_q     <= '0;
            wben_q   <= 1'b0;
        end else begin
            state    <= state_nx;
            pend     <= pend_nx;
            cur_addr <= addr_nx;
            wb_q     <= wb_nx;
            wben_q   <= wben_nx;
        end
    end

    // Transitions: launch, skip, advance, drain, retire
    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        addr_nx  = cur_addr;
        wb_nx    = wb_q;
        wben_nx  = wben_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    pend_nx  = reg_list;
                    addr_nx  = calc_first;
                    wb_nx    = calc_final;
                    wben_nx  = wb_en;
                    state_nx = (reg_list == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                pend_nx = pend & ~pick_oh;
                addr_nx = cur_addr + ADDR_W'(STEP);
                if (pick_single) state_nx = ST_FIN;
            end
            ST_FIN: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        xfer_valid = (state == ST_RUN);
        xfer_idx   = pick_idx;
        xfer_addr  = cur_addr;
        xfer_last  = (state == ST_RUN) && pick_single;
        done       = (state == ST_FIN);
        wb_valid   = (state == ST_FIN) && wben_q;
        wb_addr    = wb_q;
    end

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LIST_W-1:0] reg_list,
    input logic              busy,
    input logic              xfer_valid,
    input logic [IDX_W-1:0]  xfer_idx,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              xfer_last,
    input logic              done,
    input logic              wb_valid
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xfer_valid && !done && !wb_valid));

    a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_last) |=>
            (xfer_valid && xfer_addr == $past(xfer_addr) + 32'd4
             && xfer_idx > $past(xfer_idx)));

    a_r7_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_last) |=> (done && !xfer_valid));

    a_r7_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    a_r8_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && reg_list == '0) |=> (done && !xfer_valid));

    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && xfer_valid && !xfer_last) |=> xfer_valid);

endmodule

bind blk_xfer_agen agen_checker #(
    .ADDR_W (ADDR_W),
    .LIST_W (LIST_W)
) u_agen_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .reg_list   (reg_list),
    .busy       (busy),
    .xfer_valid (xfer_valid),
    .xfer_idx   (xfer_idx),
    .xfer_addr  (xfer_addr),
    .xfer_last  (xfer_last),
    .done       (done),
    .wb_valid   (wb_valid)
);

// File: tb/blk_xfer_agen_bench.sv
module blk_xfer_agen_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_list = '0;
    logic [1:0]  mode_sel = '0;
    logic        alias_en = 1'b0;
    logic        is_load = 1'b0;
    logic [1:0]  stack_kind = '0;
    logic        wb_en = 1'b0;
    logic        busy, xfer_valid, xfer_last, done, wb_valid;
    logic [3:0]  xfer_idx;
    logic [31:0] xfer_addr, wb_addr;

    typedef struct packed {
        logic        bsy;
        logic        xv;
        logic [3:0]  idx;
        logic [31:0] addr;
        logic        last;
        logic        dn;
        logic        wbv;
        logic [31:0] wba;
    } exp_t;

    exp_t  expq[$];
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #(CLK_P/2) clk = ~clk;

    blk_xfer_agen u_blk_xfer_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .mode_sel(mode_sel), .alias_en(alias_en),
        .is_load(is_load), .stack_kind(stack_kind), .wb_en(wb_en),
        .busy(busy), .xfer_valid(xfer_valid), .xfer_idx(xfer_idx),
        .xfer_addr(xfer_addr), .xfer_last(xfer_last), .done(done),
        .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare one cycle of outputs with the front of the model queue
    task automatic tick();
        exp_t e;
        @(negedge clk);
        e = '0;
        if (expq.size() > 0) e = expq.pop_front();
        cmp("busy", 32'(busy), 32'(e.bsy));
        cmp("xfer_valid", 32'(xfer_valid), 32'(e.xv));
        cmp("done", 32'(done), 32'(e.dn));
        cmp("wb_valid", 32'(wb_valid), 32'(e.wbv));
        if (e.xv) begin
            cmp("xfer_idx", 32'(xfer_idx), 32'(e.idx));
            cmp("xfer_addr", xfer_addr, e.addr);
            cmp("xfer_last", 32'(xfer_last), 32'(e.last));
        end
        if (e.wbv) cmp("wb_addr", wb_addr, e.wba);
    endtask

    // Independent stack-discipline resolution (kind: bit1 ascending, bit0 empty)
    function automatic int resolve(logic al, logic ld, logic [1:0] kind, logic [1:0] dm);
        if (!al) return int'(dm);
        if (ld) begin
            case (kind)
                2'b00: return 0;   // full descending
                2'b01: return 1;   // empty descending
                2'b10: return 2;   // full ascending
                default: return 3; // empty ascending
            endcase
        end
        case (kind)
            2'b11: return 0;   // empty ascending
            2'b10: return 1;   // full ascending
            2'b01: return 2;   // empty descending
            default: return 3; // full descending
        endcase
    endfunction

    task automatic push_model(logic [31:0] b, logic [15:0] l, int m, logic we);
        int          n;
        logic [31:0] a;
        logic [31:0] wbv;
        int          k;
        exp_t        e;
        n = $countones(l);
        case (m)
            0: a = b;
            1: a = b + 32'd4;
            2: a = b - 32'(4 * n) + 32'd4;
            default: a = b - 32'(4 * n);
        endcase
        wbv = (m >= 2) ? b - 32'(4 * n) : b + 32'(4 * n);
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                k++;
                e = '0;
                e.bsy = 1'b1; e.xv = 1'b1; e.idx = 4'(i);
                e.addr = a; e.last = (k == n);
                expq.push_back(e);
                a = a + 32'd4;
            end
        end
        e = '0;
        e.bsy = 1'b1; e.dn = 1'b1; e.wbv = we; e.wba = wbv;
        expq.push_back(e);
    endtask

    task automatic run_op(string tag, logic [31:0] b, logic [15:0] l, logic [1:0] dm,
                          logic al, logic ld, logic [1:0] kind, logic we, logic intrude);
        cur_req = tag;
        base_addr = b; reg_list = l; mode_sel = dm; alias_en = al;
        is_load = ld; stack_kind = kind; wb_en = we; start = 1'b1;
        push_model(b, l, resolve(al, ld, kind, dm), we);
        tick();
        start = 1'b0;
        if (intrude) begin
            // R11: second start while busy, different operands
            base_addr = 32'hDEAD_0000; reg_list = 16'h00FF; mode_sel = 2'd3; wb_en = ~we;
            start = 1'b1;
            tick();
            start = 1'b0;
            tick();
            start = 1'b1;
            tick();
            start = 1'b0;
        end
        while (expq.size() > 0) tick();
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        run_op("R2", 32'h0000_1000, 16'h8421, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R3", 32'h0000_2000, 16'h0007, 2'd1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
        run_op("R4", 32'h0000_3000, 16'hF000, 2'd2, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R5", 32'h0000_4000, 16'hFFFF, 2'd3, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R6", 32'h0000_5000, 16'h0001, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R6", 32'h0000_6000, 16'h8000, 2'd3, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R7", 32'h0000_0008, 16'h00F0, 2'd3, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R7", 32'hFFFF_FFF0, 16'h0A0A, 2'd1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
        run_op("R8", 32'h0000_7000, 16'h0000, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        run_op("R8", 32'h0000_7100, 16'h0000, 2'd3, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            run_op("R9", 32'h0000_8000, 16'h1234, 2'(3 - k), 1'b1, 1'b1, 2'(k), 1'b1, 1'b0);
            run_op("R10", 32'h0000_9000, 16'h4321, 2'(k), 1'b1, 1'b0, 2'(k), 1'b1, 1'b0);
        end
        run_op("R11", 32'h0000_A000, 16'h0F0F, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);
        run_op("R11", 32'h0000_B000, 16'h0300, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
        cur_req = "R1";
        repeat (3) tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule